// File: doc/BRIEF.md
# Memory Cycle Sequencer for a Three-Stage CPU

This block decides what each memory transaction of a small 16-bit, three-stage pipelined processor is used for: an instruction fetch, a DMA transfer, or the data access of a load or store in the execute stage. It tracks the kind of the transaction under way and chooses the next one each time the memory controller signals completion. It also drives the per-transaction attributes (direction, width, data-bus use) and the pipeline advance enable that the datapath registers use.

A pipeline cycle is made of zero or more inserted memory cycles (DMA first, then at most one load/store) followed by the instruction fetch. The pipeline advances only when that closing fetch completes. A pending-DMA bit and a pending-interrupt bit hold requests until they are served. A pending interrupt is taken at the next pipeline advance, and a strobe tells the fetch path to replace the fetched word with the interrupt instruction.

Flags on `ex_ldst`, `ex_store` and `ex_byte` describe the execute-stage instruction of the pipeline cycle that the next memory cycle belongs to. They are sampled on each completion edge.

Top module: `memcyc_ctrl`

## Requirements
- R1: While reset is applied, and until the first completion after it, `cur_cycle` reads 0 (fetch), `dma_pend` and `int_pend` are 0, and `pipe_ce` is 0 when `mem_rdy` is 0.
- R2: `cur_cycle` changes only on a clock edge where `mem_rdy` is 1. With `mem_rdy` low it holds and `pipe_ce` stays 0.
- R3: `addr_ce` equals `mem_rdy` in every cycle.
- R4: `pipe_ce` is 1 exactly when `mem_rdy` is 1 and `cur_cycle` is 0 (fetch). No other memory cycle ends a pipeline cycle.
- R5: On a completion edge the next cycle is DMA (`cur_cycle`=1) if a DMA is pending. Otherwise it is load/store (`cur_cycle`=2) if the execute instruction is a load/store not yet served. Otherwise it is fetch (0).
- R6: Each pipeline cycle gets at most one load/store memory cycle. After it, the next cycle is a fetch even with `ex_ldst` still high.
- R7: `nxt_read` is 0 only when the next cycle is a load/store and `ex_store` is 1. Otherwise it is 1.
- R8: `nxt_word` is 0 only when the next cycle is a load/store and `ex_byte` is 1. Otherwise it is 1.
- R9: `nxt_dbus` is 1 exactly when the next cycle is a load/store.
- R10: A one-clock pulse on `dma_req` sets `dma_pend` on that edge. `dma_pend` clears on the edge that starts the DMA cycle. A request arriving on that same edge keeps it set.
- R11: A pulse on `irq_req` sets `int_pend`. `int_take` is 1 when `pipe_ce` and `int_pend` are both 1, and `int_pend` is 0 after that edge unless a new request arrived on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_rdy | input | 1 | Current memory transaction completes this cycle |
| dma_req | input | 1 | One-clock DMA request pulse |
| irq_req | input | 1 | One-clock interrupt request pulse |
| ex_ldst | input | 1 | Execute-stage instruction is a load or store |
| ex_store | input | 1 | Execute-stage access is a store |
| ex_byte | input | 1 | Execute-stage access is a byte access |
| addr_ce | output | 1 | Next address and attributes valid; start a new transaction |
| nxt_read | output | 1 | Next transaction is a read |
| nxt_word | output | 1 | Next transaction is 16-bit wide |
| nxt_dbus | output | 1 | Next transaction is a load/store using the data bus |
| pipe_ce | output | 1 | Pipeline advance enable |
| cur_cycle | output | 2 | Kind of current cycle: 0 fetch, 1 DMA, 2 load/store |
| dma_pend | output | 1 | DMA request waiting |
| int_pend | output | 1 | Interrupt request waiting |
| int_take | output | 1 | Insert interrupt instruction at this pipeline advance |

## Verification
The sequencer is driven with back-to-back fetches and with fetches stalled by a low `mem_rdy`. Together these separate the hold behaviour from the advance enable. Store-word and load-byte instructions show that direction and width are decoded independently. A DMA request combined with a pending load/store shows the ordering DMA, then load/store, then fetch, and that only one load/store is served. A DMA request that lands on the very edge its predecessor starts, and an interrupt taken at a fetch completion, check that the pending bits are set and cleared in the right order.

// File: rtl/memcyc_pkg.sv
package memcyc_pkg;
  typedef enum logic [1:0] {
    CYC_FETCH = 2'd0,
    CYC_DMA   = 2'd1,
    CYC_LDST  = 2'd2
  } cyc_e;
endpackage

// File: rtl/memcyc_rst_sync.sv
module memcyc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/memcyc_pend.sv
module memcyc_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic clr,
  output logic pend
);
  logic pend_d;

  // a new request on the clearing edge wins
  always_comb pend_d = req | (pend & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= 1'b0;
    else        pend <= pend_d;
  end
endmodule

// File: rtl/memcyc_sel.sv
module memcyc_sel
  import memcyc_pkg::*;
(
  input  cyc_e cur,
  input  logic dma_pend,
  input  logic ex_ldst,
  input  logic ls_done,
  output cyc_e nxt
);
  logic ldst_owed;

  // leaving a fetch starts a new pipeline cycle, so the served flag is stale
  always_comb ldst_owed = ex_ldst & ((cur == CYC_FETCH) | ~ls_done);

  always_comb begin
    if (dma_pend)       nxt = CYC_DMA;
    else if (ldst_owed) nxt = CYC_LDST;
    else                nxt = CYC_FETCH;
  end
endmodule

// File: rtl/memcyc_ctrl.sv
module memcyc_ctrl
  import memcyc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mem_rdy,
  input  logic       dma_req,
  input  logic       irq_req,
  input  logic       ex_ldst,
  input  logic       ex_store,
  input  logic       ex_byte,
  output logic       addr_ce,
  output logic       nxt_read,
  output logic       nxt_word,
  output logic       nxt_dbus,
  output logic       pipe_ce,
  output logic [1:0] cur_cycle,
  output logic       dma_pend,
  output logic       int_pend,
  output logic       int_take
);
  logic rst_q_n;
  cyc_e cur_q, cur_d, nxt;
  logic ls_done_q, ls_done_d;
  logic dma_clr;

  memcyc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_q_n)
  );

  memcyc_sel u_sel (
    .cur      (cur_q),
    .dma_pend (dma_pend),
    .ex_ldst  (ex_ldst),
    .ls_done  (ls_done_q),
    .nxt      (nxt)
  );

  // next-state logic
  always_comb begin
    cur_d     = cur_q;
    ls_done_d = ls_done_q;
    if (mem_rdy) begin
      cur_d = nxt;
      if (nxt == CYC_LDST)       ls_done_d = 1'b1;
      else if (cur_q == CYC_FETCH) ls_done_d = 1'b0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cur_q     <= CYC_FETCH;
      ls_done_q <= 1'b0;
    end else begin
      cur_q     <= cur_d;
      ls_done_q <= ls_done_d;
    end
  end

  always_comb begin
    addr_ce   = mem_rdy;
    pipe_ce   = mem_rdy & (cur_q == CYC_FETCH);
    nxt_dbus  = (nxt == CYC_LDST);
    nxt_read  = ~(nxt_dbus & ex_store);
    nxt_word  = ~(nxt_dbus & ex_byte);
    int_take  = pipe_ce & int_pend;
    dma_clr   = mem_rdy & (nxt == CYC_DMA);
    cur_cycle = cur_q;
  end

  memcyc_pend u_dma (
    .clk   (clk),
    .rst_n (rst_q_n),
    .req   (dma_req),
    .clr   (dma_clr),
    .pend  (dma_pend)
  );

  memcyc_pend u_int (
    .clk   (clk),
    .rst_n (rst_q_n),
    .req   (irq_req),
    .clr   (int_take),
    .pend  (int_pend)
  );
endmodule

// File: rtl/memcyc_ctrl_chk.sv
module memcyc_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mem_rdy,
  input logic       irq_req,
  input logic       addr_ce,
  input logic       nxt_read,
  input logic       nxt_word,
  input logic       nxt_dbus,
  input logic       pipe_ce,
  input logic [1:0] cur_cycle,
  input logic       dma_pend,
  input logic       int_pend,
  input logic       int_take
);
  p_ace_r3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ce == mem_rdy);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rdy |=> $stable(cur_cycle));

  p_pce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pipe_ce |-> (mem_rdy && cur_cycle == 2'd0));

  p_dma_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_pend && mem_rdy) |=> cur_cycle == 2'd1);

  p_store_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !nxt_read |-> nxt_dbus);

  p_byte_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !nxt_word |-> nxt_dbus);

  p_dbus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (nxt_dbus && mem_rdy) |=> cur_cycle == 2'd2);

  p_int_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (int_take && !irq_req) |=> !int_pend);

  p_legal_state_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cur_cycle != 2'd3);
endmodule

bind memcyc_ctrl memcyc_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .mem_rdy   (mem_rdy),
  .irq_req   (irq_req),
  .addr_ce   (addr_ce),
  .nxt_read  (nxt_read),
  .nxt_word  (nxt_word),
  .nxt_dbus  (nxt_dbus),
  .pipe_ce   (pipe_ce),
  .cur_cycle (cur_cycle),
  .dma_pend  (dma_pend),
  .int_pend  (int_pend),
  .int_take  (int_take)
);

// File: tb/memcyc_ctrl_tb_top.sv
module memcyc_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       mem_rdy, dma_req, irq_req, ex_ldst, ex_store, ex_byte;
  logic       addr_ce, nxt_read, nxt_word, nxt_dbus, pipe_ce;
  logic [1:0] cur_cycle;
  logic       dma_pend, int_pend, int_take;
  int         n_chk = 0;
  int         n_fail = 0;
  logic       done = 1'b0;

  always #10 clk = ~clk;

  memcyc_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .mem_rdy(mem_rdy), .dma_req(dma_req),
    .irq_req(irq_req), .ex_ldst(ex_ldst), .ex_store(ex_store),
    .ex_byte(ex_byte), .addr_ce(addr_ce), .nxt_read(nxt_read),
    .nxt_word(nxt_word), .nxt_dbus(nxt_dbus), .pipe_ce(pipe_ce),
    .cur_cycle(cur_cycle), .dma_pend(dma_pend), .int_pend(int_pend),
    .int_take(int_take)
  );

  task automatic chk(input string req, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  // advance one clock; return just after the falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; mem_rdy = 1'b0; dma_req = 1'b0; irq_req = 1'b0;
    ex_ldst = 1'b0; ex_store = 1'b0; ex_byte = 1'b0;
    tick(); tick();
    settle();
    chk("R1", "cur_cycle in reset", cur_cycle, 0);
    chk("R1", "dma_pend in reset", dma_pend, 0);
    chk("R1", "int_pend in reset", int_pend, 0);
    chk("R1", "pipe_ce in reset", pipe_ce, 0);
    rst_n = 1'b1;
    tick(); tick(); tick(); tick();
    settle();
    chk("R1", "cur_cycle after release", cur_cycle, 0);
  endtask

  task automatic t_stall();
    mem_rdy = 1'b0;
    settle();
    chk("R2", "pipe_ce while stalled", pipe_ce, 0);
    chk("R3", "addr_ce while stalled", addr_ce, 0);
    ex_ldst = 1'b1;
    tick(); tick();
    settle();
    chk("R2", "cur_cycle held", cur_cycle, 0);
    ex_ldst = 1'b0;
  endtask

  task automatic t_fetch_run();
    mem_rdy = 1'b1;
    settle();
    chk("R4", "pipe_ce on fetch done", pipe_ce, 1);
    chk("R3", "addr_ce follows rdy", addr_ce, 1);
    chk("R9", "nxt_dbus plain fetch", nxt_dbus, 0);
    chk("R7", "nxt_read plain fetch", nxt_read, 1);
    chk("R8", "nxt_word plain fetch", nxt_word, 1);
    tick();
    settle();
    chk("R5", "fetch follows fetch", cur_cycle, 0);
    mem_rdy = 1'b0;
  endtask

  task automatic t_store_word();
    ex_ldst = 1'b1; ex_store = 1'b1; ex_byte = 1'b0; mem_rdy = 1'b1;
    settle();
    chk("R9", "nxt_dbus store", nxt_dbus, 1);
    chk("R7", "nxt_read store", nxt_read, 0);
    chk("R8", "nxt_word store word", nxt_word, 1);
    tick();
    settle();
    chk("R5", "ldst cycle entered", cur_cycle, 2);
    chk("R4", "pipe_ce in ldst", pipe_ce, 0);
    chk("R6", "no second ldst", nxt_dbus, 0);
    chk("R7", "nxt_read after ldst", nxt_read, 1);
    tick();
    settle();
    chk("R6", "fetch after ldst", cur_cycle, 0);
    mem_rdy = 1'b0; ex_ldst = 1'b0; ex_store = 1'b0;
  endtask

  task automatic t_load_byte();
    ex_ldst = 1'b1; ex_store = 1'b0; ex_byte = 1'b1; mem_rdy = 1'b1;
    settle();
    chk("R7", "nxt_read load byte", nxt_read, 1);
    chk("R8", "nxt_word load byte", nxt_word, 0);
    tick();
    settle();
    chk("R5", "ldst for byte load", cur_cycle, 2);
    chk("R8", "nxt_word after ldst", nxt_word, 1);
    tick();
    mem_rdy = 1'b0; ex_ldst = 1'b0; ex_byte = 1'b0;
  endtask

  task automatic t_dma_order();
    mem_rdy = 1'b0; dma_req = 1'b1; ex_ldst = 1'b1;
    tick();
    dma_req = 1'b0;
    settle();
    chk("R10", "dma_pend set", dma_pend, 1);
    chk("R2", "cur held with dma", cur_cycle, 0);
    mem_rdy = 1'b1;
    settle();
    chk("R4", "pipe_ce before dma", pipe_ce, 1);
    chk("R5", "dma ahead of ldst", nxt_dbus, 0);
    tick();
    settle();
    chk("R5", "dma cycle entered", cur_cycle, 1);
    chk("R10", "dma_pend cleared", dma_pend, 0);
    chk("R5", "ldst after dma", nxt_dbus, 1);
    tick();
    settle();
    chk("R5", "ldst cycle after dma", cur_cycle, 2);
    chk("R6", "fetch owed", nxt_dbus, 0);
    tick();
    settle();
    chk("R6", "fetch closes cycle", cur_cycle, 0);
    mem_rdy = 1'b0; ex_ldst = 1'b0;
  endtask

  task automatic t_dma_same_edge();
    mem_rdy = 1'b0; dma_req = 1'b1;
    tick();
    mem_rdy = 1'b1;
    settle();
    tick();
    dma_req = 1'b0;
    settle();
    chk("R10", "cycle is dma", cur_cycle, 1);
    chk("R10", "new request kept", dma_pend, 1);
    tick();
    settle();
    chk("R10", "second dma", cur_cycle, 1);
    chk("R10", "pend finally clear", dma_pend, 0);
    tick();
    settle();
    chk("R5", "back to fetch", cur_cycle, 0);
    mem_rdy = 1'b0;
  endtask

  task automatic t_interrupt();
    mem_rdy = 1'b0; irq_req = 1'b1;
    tick();
    irq_req = 1'b0;
    settle();
    chk("R11", "int_pend set", int_pend, 1);
    chk("R11", "no take while stalled", int_take, 0);
    mem_rdy = 1'b1;
    settle();
    chk("R11", "int_take at advance", int_take, 1);
    tick();
    mem_rdy = 1'b0;
    settle();
    chk("R11", "int_pend cleared", int_pend, 0);
    chk("R11", "int_take low", int_take, 0);
  endtask

  initial begin
    t_reset();
    t_stall();
    t_fetch_run();
    t_store_word();
    t_load_byte();
    t_dma_order();
    t_dma_same_edge();
    t_interrupt();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule